// File: doc/BRIEF.md
# Thread-Tagged Operand Hazard and Bypass Unit

This unit sits at the decode stage of a pipelined processor that interleaves two hardware threads. For each of the two source operands of the instruction in decode, it looks at the destination tags of the three instructions further down the pipe. Each tag holds the thread number, the register number and a write flag. The unit then picks where the operand value comes from: the register file, or one of the three downstream result buses. When the closest matching producer has not yet produced its result, the unit holds decode instead.

The unit keeps its own three-entry copy of the downstream destination tags. When decode holds a valid instruction and is not held, that instruction's tag enters the first slot. Otherwise a write-disabled bubble enters the first slot. All slots advance on every clock. A tag only ever matches an operand of the same thread, so the two threads never stall each other. The execution units report, for each slot, whether that slot's result is ready and what its value is.

Top module: `hzfw_unit`

## Requirements
- R1: After reset, all three tag slots are empty. A valid decode instruction with any source registers sees stall low and select code 0 on both operands.
- R2: A slot matches an operand only when three conditions hold together: the slot's write flag is 1, its register number equals the operand's register number, and its thread number equals the decode thread number.
- R3: Source register 0 never matches and never stalls. Its operand value is always 0, whatever the register-file data.
- R4: The select code tells where each operand comes from: 0 is the register file, 1 is the slot right after decode, 2 is the slot after that, and 3 is the oldest slot. When the chosen producer is ready, the operand equals that slot's result bus.
- R5: When several slots match one operand, only the youngest matching slot (the lowest select code) counts. Older matches are ignored.
- R6: Stall is high when decode is valid and, for either operand, the youngest matching slot has its ready flag low. This holds even when an older matching slot is ready. Stall goes low in the first cycle in which that slot's ready flag is high.
- R7: In a cycle with stall high, the first slot receives a bubble with its write flag at 0. The held instruction enters the first slot in the cycle after stall goes low.
- R8: Stall is never high while decode is not valid. A cycle with decode not valid inserts a bubble.
- R9: An operand with no matching slot has select code 0 and takes the register-file value.
- R10: Stall is never high for more than three consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_tid | input | 1 | Thread number of the decode instruction |
| dec_rs_a | input | 5 | First source register |
| dec_rs_b | input | 5 | Second source register |
| dec_we | input | 1 | Decode instruction writes a register |
| dec_rd | input | 5 | Destination register of the decode instruction |
| rf_data_a | input | 32 | Register-file value for the first source |
| rf_data_b | input | 32 | Register-file value for the second source |
| stg_rdy | input | 3 | Result-ready flag per slot, bit 0 youngest |
| stg_data | input | 96 | Result bus per slot, bits 31:0 youngest |
| op_a | output | 32 | Resolved first operand |
| op_b | output | 32 | Resolved second operand |
| sel_a | output | 2 | Source code of the first operand |
| sel_b | output | 2 | Source code of the second operand |
| stall | output | 1 | Hold the decode instruction |

## Verification
Directed sequences place a producer one, two and three slots ahead. This shows that each select code and result bus is wired to the right slot. A same-register write from the other thread, a write-disabled producer and writes to register 0 show that the tag comparison needs all of its fields. Back-to-back writers to one register separate youngest-first priority from older-first priority. Load-like producers with ready held low show how long the stall lasts, when it releases and whether bubbles are inserted. A long pseudorandom run uses a small register range and random ready flags to mix all of these cases, and compares against a behavioural queue model on every cycle.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;
    parameter int XLEN = 32;
    parameter int RW   = 5;
    parameter int TW   = 1;
    parameter int NSTG = 3;
    parameter int SELW = $clog2(NSTG + 1);
    parameter int RUNW = $clog2(NSTG + 2);

    typedef struct packed {
        logic          we;
        logic [TW-1:0] tid;
        logic [RW-1:0] rd;
    } dtag_t;
endpackage

// File: rtl/hzfw_tag_pipe.sv
module hzfw_tag_pipe
    import hzfw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_i,
    input  dtag_t                  new_tag_i,
    output dtag_t [NSTG-1:0]       stg_o
);
    typedef struct packed {
        dtag_t [NSTG-1:0] stg;
    } pipe_st_t;

    pipe_st_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int k = NSTG - 1; k > 0; k--) begin
            state_d.stg[k] = state_q.stg[k-1];
        end
        if (issue_i) begin
            state_d.stg[0] = new_tag_i;
        end else begin
            state_d.stg[0] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stg_o = state_q.stg;

    // a held or empty decode slot must leave a write-disabled bubble behind
    assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !stg_o[0].we);

    // a tag taken at issue reappears one slot further down on the next edge
    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> stg_o[0] == $past(new_tag_i));
endmodule

// File: rtl/hzfw_opnd_sel.sv
module hzfw_opnd_sel
    import hzfw_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [TW-1:0]                  tid_i,
    input  logic [RW-1:0]                  rs_i,
    input  dtag_t [NSTG-1:0]               stg_i,
    input  logic [NSTG-1:0]                rdy_i,
    input  logic [NSTG-1:0][XLEN-1:0]      data_i,
    input  logic [XLEN-1:0]                rf_i,
    output logic [SELW-1:0]                sel_o,
    output logic [XLEN-1:0]                data_o,
    output logic                           wait_o
);
    logic [NSTG-1:0] hit;
    logic            rs_zero;

    assign rs_zero = (rs_i == '0);

    for (genvar k = 0; k < NSTG; k++) begin : g_cmp
        assign hit[k] = stg_i[k].we && !rs_zero &&
                        (stg_i[k].rd == rs_i) && (stg_i[k].tid == tid_i);

        // a chosen slot must carry the same thread, register and write flag
        assert_thread_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_o == SELW'(k + 1)) |->
                (stg_i[k].we && stg_i[k].tid == tid_i && stg_i[k].rd == rs_i));
    end

    always_comb begin
        sel_o  = '0;
        data_o = rs_zero ? '0 : rf_i;
        wait_o = 1'b0;
        // walk oldest to youngest so the closest producer is the last to win
        for (int k = NSTG - 1; k >= 0; k--) begin
            if (hit[k]) begin
                sel_o  = SELW'(k + 1);
                data_o = data_i[k];
                wait_o = !rdy_i[k];
            end
        end
    end

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_i == '0) |-> (sel_o == '0 && data_o == '0 && !wait_o));

    assert_wait_has_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (sel_o != '0));
endmodule

// File: rtl/hzfw_unit.sv
module hzfw_unit
    import hzfw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dec_valid,
    input  logic [TW-1:0]          dec_tid,
    input  logic [RW-1:0]          dec_rs_a,
    input  logic [RW-1:0]          dec_rs_b,
    input  logic                   dec_we,
    input  logic [RW-1:0]          dec_rd,
    input  logic [XLEN-1:0]        rf_data_a,
    input  logic [XLEN-1:0]        rf_data_b,
    input  logic [NSTG-1:0]        stg_rdy,
    input  logic [NSTG*XLEN-1:0]   stg_data,
    output logic [XLEN-1:0]        op_a,
    output logic [XLEN-1:0]        op_b,
    output logic [SELW-1:0]        sel_a,
    output logic [SELW-1:0]        sel_b,
    output logic                   stall
);
    localparam int NOPND = 2;

    dtag_t [NSTG-1:0]             stg_tag;
    dtag_t                        new_tag;
    logic                         issue;
    logic [NSTG-1:0][XLEN-1:0]    data_arr;
    logic [NOPND-1:0][RW-1:0]     rs_arr;
    logic [NOPND-1:0][XLEN-1:0]   rf_arr;
    logic [NOPND-1:0][XLEN-1:0]   op_arr;
    logic [NOPND-1:0][SELW-1:0]   sel_arr;
    logic [NOPND-1:0]             wait_arr;

    for (genvar k = 0; k < NSTG; k++) begin : g_bus
        assign data_arr[k] = stg_data[k*XLEN +: XLEN];
    end

    assign rs_arr = {dec_rs_b, dec_rs_a};
    assign rf_arr = {rf_data_b, rf_data_a};

    for (genvar p = 0; p < NOPND; p++) begin : g_opnd
        hzfw_opnd_sel u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .tid_i  (dec_tid),
            .rs_i   (rs_arr[p]),
            .stg_i  (stg_tag),
            .rdy_i  (stg_rdy),
            .data_i (data_arr),
            .rf_i   (rf_arr[p]),
            .sel_o  (sel_arr[p]),
            .data_o (op_arr[p]),
            .wait_o (wait_arr[p])
        );
    end

    assign stall   = dec_valid && (|wait_arr);
    assign issue   = dec_valid && !stall;
    assign new_tag = '{we: dec_we, tid: dec_tid, rd: dec_rd};

    hzfw_tag_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue),
        .new_tag_i (new_tag),
        .stg_o     (stg_tag)
    );

    assign op_a  = op_arr[0];
    assign op_b  = op_arr[1];
    assign sel_a = sel_arr[0];
    assign sel_b = sel_arr[1];

    // consecutive stall cycles, kept only to bound the stall window
    logic [RUNW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!stall) begin
            run_d = '0;
        end else if (run_q != RUNW'(NSTG + 1)) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assert_stall_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);

    assert_stall_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (run_q < RUNW'(NSTG)));
endmodule

// File: tb/hzfw_unit_tb_top.sv
module hzfw_unit_tb_top;
    import hzfw_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 dec_valid = 1'b0;
    logic [TW-1:0]        dec_tid = '0;
    logic [RW-1:0]        dec_rs_a = '0, dec_rs_b = '0, dec_rd = '0;
    logic                 dec_we = 1'b0;
    logic [XLEN-1:0]      rf_data_a = '0, rf_data_b = '0;
    logic [NSTG-1:0]      stg_rdy = '0;
    logic [NSTG*XLEN-1:0] stg_data = '0;
    logic [XLEN-1:0]      op_a, op_b;
    logic [SELW-1:0]      sel_a, sel_b;
    logic                 stall;

    hzfw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_tid(dec_tid),
        .dec_rs_a(dec_rs_a), .dec_rs_b(dec_rs_b), .dec_we(dec_we), .dec_rd(dec_rd),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b), .stg_rdy(stg_rdy),
        .stg_data(stg_data), .op_a(op_a), .op_b(op_b), .sel_a(sel_a),
        .sel_b(sel_b), .stall(stall)
    );

    int n_chk = 0;
    int n_bad = 0;
    int ncyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    bit last_stall = 1'b0;

    // behavioural model: queue of downstream tags, front = youngest
    typedef struct { bit we; int tid; int rd; } mtag_t;
    mtag_t mq[$];

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic void model_op(int rs, int tid, logic [XLEN-1:0] rf,
                                     output int sel, output logic [XLEN-1:0] val,
                                     output bit wt);
        sel = 0; wt = 0; val = (rs == 0) ? '0 : rf;
        if (rs != 0) begin
            for (int k = 0; k < mq.size(); k++) begin
                if (mq[k].we && mq[k].rd == rs && mq[k].tid == tid) begin
                    sel = k + 1;
                    val = stg_data[k*XLEN +: XLEN];
                    wt  = !stg_rdy[k];
                    break;
                end
            end
        end
    endfunction

    task automatic step(bit v, int tid, int ra, int rb, bit we, int rd, bit [2:0] rdy);
        int sa, sb;
        logic [XLEN-1:0] va, vb;
        bit wa, wb, exp_stall;
        @(negedge clk);
        dec_valid = v; dec_tid = TW'(tid); dec_rs_a = RW'(ra); dec_rs_b = RW'(rb);
        dec_we = we; dec_rd = RW'(rd); stg_rdy = rdy;
        rf_data_a = 32'hAA00_0000 + ncyc;
        rf_data_b = 32'hBB00_0000 + ncyc;
        for (int k = 0; k < NSTG; k++)
            stg_data[k*XLEN +: XLEN] = 32'h1000_0000 * (k + 1) + ncyc;
        #1;
        model_op(ra, tid, rf_data_a, sa, va, wa);
        model_op(rb, tid, rf_data_b, sb, vb, wb);
        exp_stall = v && (wa || wb);
        chk("stall", stall, exp_stall);
        if (!exp_stall) begin
            chk("sel_a", sel_a, sa);
            chk("op_a", op_a, va);
            chk("sel_b", sel_b, sb);
            chk("op_b", op_b, vb);
        end
        last_stall = exp_stall;
        if (rst_n) begin
            mtag_t t;
            t.we = v && !exp_stall && we; t.tid = tid; t.rd = rd;
            mq.push_front(t);
            void'(mq.pop_back());
        end
        ncyc++;
    endtask

    initial begin
        for (int k = 0; k < NSTG; k++) begin
            mtag_t t; t.we = 0; t.tid = 0; t.rd = 0;
            mq.push_back(t);
        end
        repeat (3) @(posedge clk);
        // R1: empty slots after reset
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1";
        step(1, 0, 3, 4, 0, 0, 3'b111);
        step(1, 1, 7, 9, 0, 0, 3'b000);
        // R9: no producer for the sources
        cur_req = "R9";
        step(1, 0, 1, 2, 1, 12, 3'b111);
        step(1, 0, 3, 4, 0, 0, 3'b111);
        // R4: producer one, two and three slots ahead
        cur_req = "R4";
        step(1, 0, 0, 0, 1, 5, 3'b111);
        step(1, 0, 5, 1, 0, 0, 3'b111);
        step(1, 0, 2, 5, 0, 0, 3'b111);
        step(1, 0, 5, 5, 0, 0, 3'b111);
        step(1, 0, 5, 5, 0, 0, 3'b111);
        // R2: other thread, and write flag low
        cur_req = "R2";
        step(1, 0, 0, 0, 1, 6, 3'b000);
        step(1, 1, 6, 6, 0, 7, 3'b000);
        step(1, 1, 7, 6, 1, 6, 3'b000);
        step(1, 0, 6, 7, 0, 0, 3'b000);
        // R3: writes to register 0
        cur_req = "R3";
        step(1, 0, 0, 0, 1, 0, 3'b000);
        step(1, 0, 0, 0, 1, 0, 3'b000);
        // R5: two writers of the same register
        cur_req = "R5";
        step(1, 0, 0, 0, 1, 8, 3'b111);
        step(1, 0, 0, 0, 1, 8, 3'b111);
        step(1, 0, 8, 8, 0, 0, 3'b111);
        // R6: youngest not ready, older ready -> stall until slot 2 ready
        cur_req = "R6";
        step(1, 0, 0, 0, 1, 9, 3'b111);
        step(1, 0, 0, 0, 1, 9, 3'b111);
        step(1, 0, 9, 0, 0, 0, 3'b110);
        step(1, 0, 9, 0, 0, 0, 3'b101);
        step(1, 0, 9, 0, 0, 0, 3'b111);
        // R8: invalid decode with a pending hazard
        cur_req = "R8";
        step(1, 1, 0, 0, 1, 11, 3'b000);
        step(0, 1, 11, 11, 0, 0, 3'b000);
        step(0, 1, 11, 11, 0, 0, 3'b000);
        // R10: worst case, nothing ready for three cycles
        cur_req = "R10";
        step(1, 0, 0, 0, 1, 13, 3'b111);
        step(1, 0, 13, 0, 1, 10, 3'b000);
        step(1, 0, 13, 0, 1, 10, 3'b000);
        step(1, 0, 13, 0, 1, 10, 3'b000);
        step(1, 0, 13, 0, 1, 10, 3'b000);
        // R7: held instruction enters after release, bubbles do not match
        cur_req = "R7";
        step(1, 0, 10, 0, 0, 0, 3'b111);
        step(1, 0, 10, 0, 0, 0, 3'b111);
        // random mix over a small register range
        cur_req = "R5";
        begin
            int t = 0, a = 0, b = 0, d = 0;
            bit w = 0, v = 1;
            for (int i = 0; i < 600; i++) begin
                if (!last_stall) begin
                    v = ($urandom % 8) != 0; t = $urandom % 2;
                    a = $urandom % 4; b = $urandom % 4;
                    w = $urandom % 2; d = $urandom % 4;
                end
                step(v, t, a, b, w, d, 3'($urandom));
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule